// File: doc/BRIEF.md
# Single-Channel DMA Sequencer with Source Address Stepping

This block is one DMA channel. It moves a programmed number of items from a source address to a fixed destination address. Each transfer is a read cycle on a simple ready-handshake bus, followed by a write cycle that carries the data just read. After every transfer the source address either stays where it is, or moves up or down. It moves by one for byte transfers and by two for word transfers. A transfer counter counts down once per transfer. When it reaches zero, the channel clears its own enable bit and can raise an interrupt.

Software programs the channel through a small register port with five registers: control, source address, destination address, transfer count and status. The channel runs only while both the channel enable bit and the master enable bit in the status register are set. Setting the channel enable follows a guarded sequence: software must first read the control register while the enable bit is 0, and only then can a write of 1 to that bit take effect. Transfers either start on their own (automatic mode) or each one waits for the external request input.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset every control bit is 0, the interrupt and master enable are 0, and no bus cycle is requested.
- R2: The channel runs transfers only while the control enable bit (control register, select 0, bit 7) and the master enable bit (status register, select 4, bit 0) are both 1.
- R3: A write of 1 to the control enable bit sets it only if a read of the control register saw that bit at 0 after the last write to the control register. A write of 1 without such a read leaves the bit at 0.
- R4: With the automatic bit (control bit 2) set, transfers begin without any request. With it clear, each transfer waits for the xfer_req input to be high.
- R5: Each transfer is a read cycle (bus_we=0) at the source address, then a write cycle (bus_we=1) at the destination address (select 2). Each cycle holds its request, address and direction until bus_rdy is high.
- R6: The transfer count (select 3) drops by one per transfer. The transfer that takes it to zero also clears the control enable bit. If the channel becomes active with a count of zero, the enable bit clears with no bus cycle.
- R7: If the interrupt enable bit (control bit 6) is 1 when the hardware clears the enable bit, irq goes high. irq stays high until software writes 1 to status bit 1. Status bit 1 reads back the pending interrupt.
- R8: The size bit (control bit 5) selects byte transfers (0) or word transfers (1) and drives bus_size. In byte mode the write data carries the read data's low byte, with the upper byte set to 0.
- R9: With the step bit (control bit 3) at 0 the source address (select 1) stays fixed. With it at 1 the address moves by 1 for bytes or 2 for words after each transfer: upward when the direction bit (control bit 4) is 0, downward when it is 1. The address wraps modulo 2^AW.
- R10: While the control enable bit is 0, a high xfer_req starts no bus cycle and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 3 | Register select (0 control, 1 source, 2 destination, 3 count, 4 status) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a control read arms the enable) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_sel |
| xfer_req | input | 1 | External transfer request, level sensitive |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_size | output | 1 | 0 byte, 1 word |
| bus_addr | output | AW | Bus cycle address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, sampled when bus_rdy is high in a read cycle |
| bus_rdy | input | 1 | Ends the current bus cycle |
| irq | output | 1 | Transfer-complete interrupt request |

## Verification
Assertions check the following on every clock: a cycle that is waiting for ready holds its address and direction, every read phase is followed by a write phase, and no transfer starts without both enables and, outside automatic mode, a request. They also check that the enable rises only when it has been armed, that the enable clears on the final transfer, that the count never drops below zero, that the interrupt is raised and held, and that the source address steps correctly. Only the bench scenarios can show the end-to-end results. These are the exact sequence of read and write addresses and data over a whole block, and the final address after a wrap below zero. They also cover the effect of a count of zero at enable time, and the absence of any bus activity while requests arrive at a disabled channel.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;
  localparam int RW = 16;

  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_e;

  typedef struct packed {
    logic en;
    logic ie;
    logic word;
    logic dec;
    logic step;
    logic autoreq;
  } chan_ctrl_t;

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_SRC  = 3'd1;
  localparam logic [2:0] SEL_DST  = 3'd2;
  localparam logic [2:0] SEL_CNT  = 3'd3;
  localparam logic [2:0] SEL_STAT = 3'd4;

  function automatic logic [1:0] step_size(input logic word);
    return word ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/dma_ctrl_regs.sv
`timescale 1ns/1ps
module dma_ctrl_regs
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          xfer_done,
  input  logic          fsm_idle,
  output chan_ctrl_t    ctrl,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          chan_active,
  output logic          cnt_zero,
  output logic          irq
);
  chan_ctrl_t    ctrl_q;
  logic          armed_q, master_q, irq_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;

  // named internal events
  logic wr_ctrl, rd_ctrl, wr_stat, last_done, zero_end, hw_clear;

  function automatic logic [AW-1:0] next_src(input logic [AW-1:0] a, input chan_ctrl_t c);
    logic [AW-1:0] amt;
    amt = AW'(step_size(c.word));
    if (!c.step) return a;
    return c.dec ? a - amt : a + amt;
  endfunction

  assign wr_ctrl     = reg_wr && (reg_sel == SEL_CTRL);
  assign rd_ctrl     = reg_rd && (reg_sel == SEL_CTRL);
  assign wr_stat     = reg_wr && (reg_sel == SEL_STAT);
  assign chan_active = ctrl_q.en && master_q;
  assign cnt_zero    = (cnt_q == '0);
  assign last_done   = xfer_done && (cnt_q == CW'(1));
  assign zero_end    = chan_active && cnt_zero && fsm_idle;
  assign hw_clear    = last_done || zero_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (wr_ctrl) begin
      armed_q <= 1'b0;
    end else if (rd_ctrl && !ctrl_q.en) begin
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.ie      <= reg_wdata[6];
        ctrl_q.word    <= reg_wdata[5];
        ctrl_q.dec     <= reg_wdata[4];
        ctrl_q.step    <= reg_wdata[3];
        ctrl_q.autoreq <= reg_wdata[2];
      end
      if (hw_clear)
        ctrl_q.en <= 1'b0;
      else if (wr_ctrl)
        ctrl_q.en <= reg_wdata[7] && (ctrl_q.en || armed_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_stat) master_q <= reg_wdata[0];
      if (hw_clear && ctrl_q.ie)
        irq_q <= 1'b1;
      else if (wr_stat && reg_wdata[1])
        irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else begin
      if (xfer_done)
        src_q <= next_src(src_q, ctrl_q);
      else if (reg_wr && reg_sel == SEL_SRC)
        src_q <= reg_wdata[AW-1:0];
      if (reg_wr && reg_sel == SEL_DST)
        dst_q <= reg_wdata[AW-1:0];
      if (xfer_done)
        cnt_q <= cnt_q - CW'(1);
      else if (reg_wr && reg_sel == SEL_CNT)
        cnt_q <= reg_wdata[CW-1:0];
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = RW'({ctrl_q, 2'b00});
      SEL_SRC:  reg_rdata = RW'(src_q);
      SEL_DST:  reg_rdata = RW'(dst_q);
      SEL_CNT:  reg_rdata = RW'(cnt_q);
      SEL_STAT: reg_rdata = RW'({irq_q, master_q});
      default:  reg_rdata = '0;
    endcase
  end

  assign ctrl     = ctrl_q;
  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign irq      = irq_q;

  p_arm_before_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.en) |-> $past(armed_q))
    else $error("R3: enable rose without arming read");

  p_clear_on_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |=> !ctrl_q.en)
    else $error("R6: enable not cleared after final transfer");

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !cnt_zero)
    else $error("R6: transfer completed with count at zero");

  p_irq_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clear && ctrl_q.ie) |=> irq_q)
    else $error("R7: interrupt not raised");

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !(wr_stat && reg_wdata[1])) |=> irq_q)
    else $error("R7: interrupt dropped without clear");

  p_step_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && ctrl_q.step && !ctrl_q.dec) |=>
      (src_q - $past(src_q)) == ($past(ctrl_q.word) ? AW'(2) : AW'(1)))
    else $error("R9: wrong upward step");

  p_step_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && ctrl_q.step && ctrl_q.dec) |=>
      ($past(src_q) - src_q) == ($past(ctrl_q.word) ? AW'(2) : AW'(1)))
    else $error("R9: wrong downward step");

  p_step_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !ctrl_q.step) |=> $stable(src_q))
    else $error("R9: fixed source address moved");
endmodule

// File: rtl/dma_xfer_fsm.sv
`timescale 1ns/1ps
module dma_xfer_fsm
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_active,
  input  logic          cnt_zero,
  input  logic          autoreq,
  input  logic          xfer_req,
  input  logic          word,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic          bus_rdy,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_size,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          xfer_start,
  output logic          xfer_done,
  output logic          fsm_idle
);
  phase_e        phase_q;
  logic [DW-1:0] hold_q;
  logic          read_end;

  function automatic logic [DW-1:0] size_mask(input logic [DW-1:0] d, input logic w);
    return w ? d : DW'(d[7:0]);
  endfunction

  assign fsm_idle   = (phase_q == PH_IDLE);
  assign xfer_start = fsm_idle && chan_active && !cnt_zero && (autoreq || xfer_req);
  assign read_end   = (phase_q == PH_READ) && bus_rdy;
  assign xfer_done  = (phase_q == PH_WRITE) && bus_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      hold_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE:  if (xfer_start) phase_q <= PH_READ;
        PH_READ:  if (bus_rdy) begin
                    phase_q <= PH_WRITE;
                    hold_q  <= size_mask(bus_rdata, word);
                  end
        PH_WRITE: if (bus_rdy) phase_q <= PH_IDLE;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  assign bus_req   = !fsm_idle;
  assign bus_we    = (phase_q == PH_WRITE);
  assign bus_size  = word;
  assign bus_addr  = bus_we ? dst_addr : src_addr;
  assign bus_wdata = hold_q;

  p_start_needs_enables_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> chan_active)
    else $error("R2: transfer started while inactive");

  p_start_needs_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !autoreq) |-> xfer_req)
    else $error("R4: transfer started without request");

  p_hold_until_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)))
    else $error("R5: bus cycle changed before ready");

  p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    read_end |=> (bus_req && bus_we))
    else $error("R5: read not followed by write");
endmodule

// File: rtl/dma_chan_seq.sv
`timescale 1ns/1ps
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic          xfer_req,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_size,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_rdy,
  output logic          irq
);
  chan_ctrl_t    ctrl;
  logic [AW-1:0] src_addr, dst_addr;
  logic          chan_active, cnt_zero, xfer_done, xfer_start, fsm_idle;

  dma_ctrl_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_sel     (reg_sel),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .xfer_done   (xfer_done),
    .fsm_idle    (fsm_idle),
    .ctrl        (ctrl),
    .src_addr    (src_addr),
    .dst_addr    (dst_addr),
    .chan_active (chan_active),
    .cnt_zero    (cnt_zero),
    .irq         (irq)
  );

  dma_xfer_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_active (chan_active),
    .cnt_zero    (cnt_zero),
    .autoreq     (ctrl.autoreq),
    .xfer_req    (xfer_req),
    .word        (ctrl.word),
    .src_addr    (src_addr),
    .dst_addr    (dst_addr),
    .bus_rdy     (bus_rdy),
    .bus_rdata   (bus_rdata),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_size    (bus_size),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .xfer_start  (xfer_start),
    .xfer_done   (xfer_done),
    .fsm_idle    (fsm_idle)
  );

  p_no_bus_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !bus_req)
    else $error("R1: bus request out of reset");

  p_off_no_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && fsm_idle) |=> !bus_req)
    else $error("R10: bus cycle while disabled");
endmodule

// File: tb/test_dma_chan_seq.sv
`timescale 1ns/1ps
module test_dma_chan_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        xfer_req = 1'b0;
  logic        bus_req, bus_we, bus_size, irq;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_rdy = 1'b0;

  int n_chk = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0, wcnt = 0;
  logic [15:0] rd_a [64];
  logic [15:0] wr_a [64];
  logic [15:0] wr_d [64];
  logic        wr_s [64];

  always #5 clk = ~clk;

  dma_chan_seq i_dma_chan_seq (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_req(xfer_req),
    .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .irq(irq)
  );

  function automatic logic [15:0] mem_val(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3};
  endfunction

  function automatic logic [15:0] exp_next(input logic [15:0] a, input bit step,
                                           input bit dec, input bit word);
    int amt;
    amt = word ? 2 : 1;
    if (!step) return a;
    return dec ? 16'(a - amt) : 16'(a + amt);
  endfunction

  assign bus_rdata = mem_val(bus_addr);

  // bus responder with random wait states
  always @(negedge clk) begin
    if (!rst_n || !bus_req) begin
      bus_rdy = 1'b0;
    end else if (wcnt == 0) begin
      bus_rdy = 1'b1;
      if (bus_we) begin
        if (n_wr < 64) begin
          wr_a[n_wr] = bus_addr; wr_d[n_wr] = bus_wdata; wr_s[n_wr] = bus_size;
        end
        n_wr++;
      end else begin
        if (n_rd < 64) rd_a[n_rd] = bus_addr;
        n_rd++;
      end
      wcnt = $urandom % 3;
    end else begin
      bus_rdy = 1'b0;
      wcnt--;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [2:0] sel, output logic [15:0] d);
    @(negedge clk);
    reg_sel = sel; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic activate(input logic [15:0] lo);
    logic [15:0] d;
    cpu_wr(3'd0, lo & 16'h007F);
    cpu_rd(3'd0, d);
    cpu_wr(3'd0, lo | 16'h0080);
  endtask

  task automatic wait_done(input string req);
    logic [15:0] d;
    bit ok;
    ok = 0;
    for (int i = 0; i < 600; i++) begin
      cpu_rd(3'd0, d);
      if (!d[7]) begin ok = 1; break; end
    end
    check(req, "channel completion", int'(ok), 1);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_case(input bit word, input bit step, input bit dec, input bit autoreq,
                          input bit ie, input logic [15:0] src, input logic [15:0] dst,
                          input int cnt);
    logic [15:0] d, a, ea, ed;
    int errs_rd, errs_wr, errs_sz;
    n_rd = 0; n_wr = 0;
    cpu_wr(3'd1, src);
    cpu_wr(3'd2, dst);
    cpu_wr(3'd3, 16'(cnt));
    cpu_wr(3'd4, 16'h0003);
    xfer_req = !autoreq;
    activate({8'h00, 1'b0, ie, word, dec, step, autoreq, 2'b00});
    wait_done("R6");
    xfer_req = 1'b0;
    idle_cycles(2);
    check("R5", "read count", n_rd, cnt);
    check("R5", "write count", n_wr, cnt);
    a = src; errs_rd = 0; errs_wr = 0; errs_sz = 0;
    for (int k = 0; k < cnt && k < 64; k++) begin
      ea = a;
      ed = word ? mem_val(ea) : {8'h00, mem_val(ea)[7:0]};
      if (rd_a[k] !== ea) begin
        errs_rd++;
        if (errs_rd == 1) $display("FAIL R9 read addr %0d: actual %0h expected %0h", k, rd_a[k], ea);
      end
      if (wr_a[k] !== dst || wr_d[k] !== ed) begin
        errs_wr++;
        if (errs_wr == 1) $display("FAIL R5 write %0d: actual %0h/%0h expected %0h/%0h",
                                   k, wr_a[k], wr_d[k], dst, ed);
      end
      if (wr_s[k] !== word) errs_sz++;
      a = exp_next(a, step, dec, word);
    end
    check("R9", "source address sequence errors", errs_rd, 0);
    check("R5", "write address/data errors", errs_wr, 0);
    check("R8", "bus size errors", errs_sz, 0);
    cpu_rd(3'd1, d);
    check("R9", "final source address", d, a);
    cpu_rd(3'd3, d);
    check("R6", "final count", d, 0);
    idle_cycles(4);
    check("R7", "irq after completion", irq, ie);
    if (ie) begin
      cpu_wr(3'd4, 16'h0003);
      #1 check("R7", "irq after clear", irq, 0);
    end
  endtask

  bit done = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "bus_req after reset", bus_req, 0);
    check("R1", "irq after reset", irq, 0);
    cpu_rd(3'd0, d);
    check("R1", "control after reset", d, 0);
    cpu_rd(3'd4, d);
    check("R1", "status after reset", d, 0);

    // R3 guarded enable
    cpu_wr(3'd1, 16'h0100);
    cpu_wr(3'd2, 16'h8000);
    cpu_wr(3'd3, 16'd2);
    cpu_wr(3'd0, 16'h0004);
    cpu_wr(3'd0, 16'h0084);
    cpu_rd(3'd0, d);
    check("R3", "enable without arming read", d[7], 0);
    cpu_wr(3'd0, 16'h0084);
    cpu_rd(3'd0, d);
    check("R3", "enable after arming read", d[7], 1);

    // R2 master enable gates the channel
    n_rd = 0; n_wr = 0;
    idle_cycles(20);
    check("R2", "no reads while master off", n_rd, 0);
    cpu_wr(3'd4, 16'h0001);
    wait_done("R2");
    check("R2", "reads after master on", n_rd, 2);

    // R10 disabled channel ignores requests
    cpu_wr(3'd3, 16'd3);
    n_rd = 0; n_wr = 0;
    xfer_req = 1'b1;
    idle_cycles(20);
    xfer_req = 1'b0;
    check("R10", "bus cycles while disabled", n_rd + n_wr, 0);
    cpu_rd(3'd3, d);
    check("R10", "count unchanged while disabled", d, 3);

    // R4 request mode waits for xfer_req
    cpu_wr(3'd3, 16'd2);
    n_rd = 0; n_wr = 0;
    activate(16'h0000);
    idle_cycles(20);
    check("R4", "no transfer without request", n_rd, 0);
    xfer_req = 1'b1;
    wait_done("R4");
    xfer_req = 1'b0;
    check("R4", "transfers after request", n_rd, 2);

    // R6 zero count clears enable with no bus cycle, R7 interrupt
    cpu_wr(3'd3, 16'd0);
    n_rd = 0; n_wr = 0;
    activate(16'h0044);
    idle_cycles(3);
    cpu_rd(3'd0, d);
    check("R6", "enable after zero count", d[7], 0);
    check("R6", "bus cycles on zero count", n_rd, 0);
    check("R7", "irq on zero count", irq, 1);
    idle_cycles(5);
    cpu_rd(3'd4, d);
    check("R7", "irq held and readable", d[1], 1);
    cpu_wr(3'd4, 16'h0003);
    #1 check("R7", "irq cleared", irq, 0);

    // directed stepping corners (R8, R9)
    run_case(1, 1, 1, 1, 1, 16'h0002, 16'h4000, 3);  // word down, wrap
    run_case(0, 1, 0, 0, 0, 16'hFFFE, 16'h4002, 4);  // byte up, wrap
    run_case(0, 0, 1, 1, 1, 16'h1234, 16'h4004, 3);  // fixed

    // constrained random
    for (int i = 0; i < 10; i++) begin
      run_case(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               16'($urandom), 16'($urandom), 1 + ($urandom % 6));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule